// File: doc/BRIEF.md
# Sample-to-Octet Frame Assembler

This block turns 14-bit conversion results from two converter channels into octet streams for one or two serial lanes. Each sample is padded to a 16-bit container by placing two zero tail bits below its least significant bit. The container is then sent as two octets, most significant half first. The octets go next to an optional scrambler and a line encoder. Neither of those is part of this block.

A two-bit mode input picks the lane layout. In the single-lane-per-converter layout, and in the aligned two-lane layout, each lane carries one converter's two octets per frame. In the shared layout, both converters go out on lane 0 in four-octet frames. A frame starts on the clock edge where `smp_valid` is accepted. Octets then leave at one per clock. A start-of-frame flag marks the first octet on each active lane.

The mode is captured while the link is idle. It is frozen once the first frame has been accepted, and only a reset releases it.

Top module: `octet_frame_packer`

## Requirements
- R1: While reset is held and just after its release, `lane0_vld`, `lane1_vld`, both start-of-frame flags and both octet outputs are all zero.
- R2: A sample `s` is sent as two octets: first `s[13:6]`, then `{s[5:0], 2'b00}`. The two tail bits are always zero.
- R3: With mode 2'b00 (and 2'b11, which acts the same), a frame is two octets on each lane. Lane 0 carries converter 0 and lane 1 carries converter 1. The first octet appears in the cycle after the edge that accepts `smp_valid`.
- R4: With mode 2'b01, both lanes carry two-octet frames in the same cycles. Their start-of-frame flags rise together, so the two samples stay aligned.
- R5: With mode 2'b10, lane 0 carries four-octet frames in this order: converter 0 high, converter 0 low, converter 1 high, converter 1 low. Lane 1 stays idle, with valid low and octet zero.
- R6: The start-of-frame flag is high only with the first octet of a frame on that lane, and never without valid.
- R7: A `smp_valid` pulse is ignored if it arrives while a frame is in progress and the lane is not on that frame's last octet. The frame in progress and its data are not disturbed.
- R8: The mode is captured from `mode_sel` on each clock while no frame has yet been accepted since reset. After that, changes to `mode_sel` have no effect until the next reset.
- R9: If `smp_valid` is accepted during the last octet of a frame, the next frame follows with no gap. If no `smp_valid` comes, the lane goes idle after the last octet, with valid low and octet zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Octet clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Lane layout: 00/11 one lane per converter, 01 aligned two lanes, 10 shared lane |
| smp_valid | input | 1 | Both sample inputs hold a new sample |
| smp0 | input | 14 | Converter 0 sample |
| smp1 | input | 14 | Converter 1 sample |
| lane0_octet | output | 8 | Lane 0 octet |
| lane0_sof | output | 1 | Lane 0 start of frame |
| lane0_vld | output | 1 | Lane 0 octet is valid |
| lane1_octet | output | 8 | Lane 1 octet |
| lane1_sof | output | 1 | Lane 1 start of frame |
| lane1_vld | output | 1 | Lane 1 octet is valid |

## Verification
The assertions check on every cycle that:
- the tail bits of each low octet are zero;
- a start-of-frame flag never appears without valid, and never twice in a row in the two-octet layouts;
- idle lanes output zero;
- lane 1 stays silent in the shared layout;
- the captured mode holds once it is frozen.

Only the bench scenarios can show the rest:
- the exact octet order for each layout;
- that a misplaced valid pulse leaves the frame intact;
- that frames run back-to-back with no gap;
- that a mode change after the first frame waits for a reset.

// File: rtl/octet_frame_packer.sv
module octet_frame_packer #(
  parameter int SMP_W  = 14,
  parameter int OCT_W  = 8,
  parameter int TAIL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_sel,
  input  logic             smp_valid,
  input  logic [SMP_W-1:0] smp0,
  input  logic [SMP_W-1:0] smp1,
  output logic [OCT_W-1:0] lane0_octet,
  output logic             lane0_sof,
  output logic             lane0_vld,
  output logic [OCT_W-1:0] lane1_octet,
  output logic             lane1_sof,
  output logic             lane1_vld
);
  localparam int LO_BITS = SMP_W - OCT_W;
  localparam logic [1:0] MODE_SHARED = 2'b10;

  logic [1:0]       mode_q, ph;
  logic             busy, locked;
  logic [SMP_W-1:0] s0_q, s1_q;

  wire four = (mode_q == MODE_SHARED);
  wire last = busy && (ph == (four ? 2'd3 : 2'd1));
  wire take = smp_valid && (!busy || last);

  wire [OCT_W-1:0] hi0 = s0_q[SMP_W-1 -: OCT_W];
  wire [OCT_W-1:0] hi1 = s1_q[SMP_W-1 -: OCT_W];
  wire [OCT_W-1:0] lo0 = {s0_q[LO_BITS-1:0], {TAIL_W{1'b0}}};
  wire [OCT_W-1:0] lo1 = {s1_q[LO_BITS-1:0], {TAIL_W{1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      locked <= 1'b0;
      busy   <= 1'b0;
      ph     <= '0;
      s0_q   <= '0;
      s1_q   <= '0;
    end else begin
      if (!locked) mode_q <= mode_sel;
      if (take) begin
        locked <= 1'b1;
        busy   <= 1'b1;
        ph     <= '0;
        s0_q   <= smp0;
        s1_q   <= smp1;
      end else if (busy) begin
        if (last) busy <= 1'b0;
        else      ph   <= ph + 2'd1;
      end
    end
  end

  always_comb begin
    lane0_octet = '0;
    if (busy) begin
      if (four) begin
        case (ph)
          2'd0:    lane0_octet = hi0;
          2'd1:    lane0_octet = lo0;
          2'd2:    lane0_octet = hi1;
          default: lane0_octet = lo1;
        endcase
      end else begin
        lane0_octet = (ph == 2'd0) ? hi0 : lo0;
      end
    end
  end

  assign lane0_vld   = busy;
  assign lane0_sof   = busy && (ph == 2'd0);
  assign lane1_vld   = busy && !four;
  assign lane1_sof   = lane1_vld && (ph == 2'd0);
  assign lane1_octet = !lane1_vld ? '0 : (ph == 2'd0) ? hi1 : lo1;
endmodule

// File: rtl/octet_frame_packer_chk.sv
module octet_frame_packer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode_q,
  input logic       locked,
  input logic [7:0] lane0_octet,
  input logic       lane0_sof,
  input logic       lane0_vld,
  input logic [7:0] lane1_octet,
  input logic       lane1_sof,
  input logic       lane1_vld
);
  AST_TAIL0_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lane0_sof) |-> lane0_octet[1:0] == 2'b00); // R2
  AST_TAIL1_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lane1_sof) |-> lane1_octet[1:0] == 2'b00); // R2
  AST_SOF0_NEEDS_VLD: assert property (@(posedge clk) disable iff (!rst_n)
    lane0_sof |-> lane0_vld); // R6
  AST_SOF1_NEEDS_VLD: assert property (@(posedge clk) disable iff (!rst_n)
    lane1_sof |-> lane1_vld); // R6
  AST_SOF_NOT_REPEATED: assert property (@(posedge clk) disable iff (!rst_n)
    (lane0_sof && mode_q != 2'b10) |=> !lane0_sof); // R6
  AST_SHARED_LANE1_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (lane0_vld && mode_q == 2'b10) |-> (!lane1_vld && lane1_octet == 8'h00)); // R5
  AST_ALIGNED_SOF: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'b01 && lane0_sof) |-> lane1_sof); // R4
  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(locked) && locked) |-> $stable(mode_q)); // R8
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !lane0_vld |-> (lane0_octet == 8'h00 && !lane0_sof)); // R9
endmodule

bind octet_frame_packer octet_frame_packer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .locked(locked),
  .lane0_octet(lane0_octet), .lane0_sof(lane0_sof), .lane0_vld(lane0_vld),
  .lane1_octet(lane1_octet), .lane1_sof(lane1_sof), .lane1_vld(lane1_vld)
);

// File: tb/test_octet_frame_packer.sv
module test_octet_frame_packer;
  logic clk = 1'b0, rst_n = 1'b0, smp_valid = 1'b0;
  logic [1:0] mode_sel = 2'b00;
  logic [13:0] smp0 = '0, smp1 = '0;
  logic [7:0] lane0_octet, lane1_octet;
  logic lane0_sof, lane0_vld, lane1_sof, lane1_vld;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  octet_frame_packer i_octet_frame_packer (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .smp_valid(smp_valid),
    .smp0(smp0), .smp1(smp1),
    .lane0_octet(lane0_octet), .lane0_sof(lane0_sof), .lane0_vld(lane0_vld),
    .lane1_octet(lane1_octet), .lane1_sof(lane1_sof), .lane1_vld(lane1_vld));

  localparam int NV = 6;
  localparam logic [29:0] VEC [NV] = '{
    {2'b00, 14'h3FFF, 14'h0000},
    {2'b01, 14'h2A55, 14'h15AA},
    {2'b10, 14'h1234, 14'h3ABC},
    {2'b11, 14'h0001, 14'h2000},
    {2'b10, 14'h3FFF, 14'h0001},
    {2'b01, 14'h0040, 14'h003F}};

  function automatic logic [7:0] hi(input logic [13:0] s); return s[13:6]; endfunction
  function automatic logic [7:0] lo(input logic [13:0] s); return {s[5:0], 2'b00}; endfunction

  task automatic chk(input string req, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] m);
    @(negedge clk);
    rst_n = 1'b0; smp_valid = 1'b0; mode_sel = m;
    @(negedge clk);
    chk("R1 reset lane0", {lane0_vld, lane0_sof, lane0_octet}, 10'h000);
    chk("R1 reset lane1", {lane1_vld, lane1_sof, lane1_octet}, 10'h000);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {lane0_vld, lane1_vld, lane0_octet}, 10'h000);
  endtask

  task automatic launch(input logic [13:0] a, input logic [13:0] b);
    smp0 = a; smp1 = b; smp_valid = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  // Called at the negedge that shows octet k of a frame.
  task automatic chk_octet(input string req, input logic [1:0] m, input int k,
                           input logic [13:0] a, input logic [13:0] b);
    logic [7:0] e0, e1;
    if (m == 2'b10) begin
      e0 = (k == 0) ? hi(a) : (k == 1) ? lo(a) : (k == 2) ? hi(b) : lo(b);
      chk({req, " lane0"}, {lane0_vld, lane0_sof, lane0_octet}, {1'b1, k == 0, e0});
      chk({req, " R5 lane1 idle"}, {lane1_vld, lane1_sof, lane1_octet}, 10'h000);
    end else begin
      e0 = (k == 0) ? hi(a) : lo(a);
      e1 = (k == 0) ? hi(b) : lo(b);
      chk({req, " lane0"}, {lane0_vld, lane0_sof, lane0_octet}, {1'b1, k == 0, e0});
      chk({req, " lane1"}, {lane1_vld, lane1_sof, lane1_octet}, {1'b1, k == 0, e1});
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // Table walk: R2 R3 R4 R5 R6 R9
    for (int v = 0; v < NV; v++) begin
      logic [1:0] m;
      int f;
      m = VEC[v][29:28];
      f = (m == 2'b10) ? 4 : 2;
      do_reset(m);
      launch(VEC[v][27:14], VEC[v][13:0]);
      for (int k = 0; k < f; k++) begin
        chk_octet(m == 2'b10 ? "R5" : m == 2'b01 ? "R4" : "R3 R2", m, k,
                  VEC[v][27:14], VEC[v][13:0]);
        if (k < f - 1) @(negedge clk);
      end
      @(negedge clk);
      chk("R9 idle after frame", {lane0_vld, lane0_sof, lane0_octet}, 10'h000);
    end

    // R7: a misplaced valid in the middle of a frame is ignored
    do_reset(2'b00);
    launch(14'h2345, 14'h1111);
    chk_octet("R7 first", 2'b00, 0, 14'h2345, 14'h1111);
    smp0 = 14'h3C3C; smp1 = 14'h0F0F; smp_valid = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0;
    chk_octet("R7 intact", 2'b00, 1, 14'h2345, 14'h1111);
    @(negedge clk);
    chk("R7 no extra frame", {lane0_vld, lane0_sof, lane0_octet}, 10'h000);

    // R9: back-to-back frames in the shared layout
    do_reset(2'b10);
    launch(14'h0ABC, 14'h3210);
    for (int k = 0; k < 4; k++) begin
      chk_octet("R9 frame A", 2'b10, k, 14'h0ABC, 14'h3210);
      if (k == 3) launch(14'h1357, 14'h2468);
      else @(negedge clk);
    end
    for (int k = 0; k < 4; k++) begin
      chk_octet("R9 frame B", 2'b10, k, 14'h1357, 14'h2468);
      @(negedge clk);
    end

    // R8: mode change after the first frame waits for reset
    do_reset(2'b10);
    launch(14'h0101, 14'h0202);
    repeat (4) @(negedge clk);
    mode_sel = 2'b00;
    @(negedge clk);
    launch(14'h3003, 14'h0330);
    for (int k = 0; k < 4; k++) begin
      chk_octet("R8 still shared", 2'b10, k, 14'h3003, 14'h0330);
      @(negedge clk);
    end
    do_reset(2'b00);
    launch(14'h3003, 14'h0330);
    chk_octet("R8 new mode after reset", 2'b00, 0, 14'h3003, 14'h0330);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule